// File: doc/BRIEF.md
# Circular Return Address Predictor

This block is a small return address stack for the fetch stage. The target predictor outside the block raises a call flag for each fetch group it predicts to be a call, and supplies the address of the instruction after that call. The block pushes that address. When the target predictor flags a return, the block pops the newest entry and offers it as the predicted target in the same cycle. A valid flag goes with the prediction. When the stack is empty the valid flag stays low, so the redirect logic takes the target from the indirect target array.

The storage is a ring of entries with a write pointer and an occupancy count. A push into a full ring replaces the oldest entry, so the most recent calls are always kept. A later pipeline stage can replace the whole ring in one cycle by supplying an image of every entry together with a pointer and a count. This is used when decode corrects a return or when the pipeline restarts. A flush input empties the ring.

Top module: `ret_addr_predictor`

## Requirements
- R1: When `ret_i` is high and the count is nonzero, `pred_valid_o` is high in that same cycle. `pred_target_o` then equals the most recently pushed address that has not yet been popped. The pop takes effect at the next clock edge.
- R2: A lone `call_i` writes `call_next_pc_i` into the slot at `top_o`. It then advances `top_o` by one and raises `count_o` by one.
- R3: When `count_o` equals DEPTH, a push replaces the oldest entry and `count_o` stays at DEPTH. Later pops then return the DEPTH newest addresses, newest first.
- R4: A return with `count_o` at zero gives `pred_valid_o` low and leaves `top_o` and `count_o` unchanged.
- R5: `load_i` replaces every entry, `top_o` and `count_o` at one clock edge. Entry i comes from `load_image_i[i*ADDR_W +: ADDR_W]`. `top_o` takes `load_top_i`, and `count_o` takes `load_count_i` clamped to DEPTH. After a load, predictions read entry (`top_o` - 1) mod DEPTH.
- R6: `flush_i` sets `count_o` and `top_o` to zero, so the next return gives no prediction. Flush takes priority over a load in the same cycle.
- R7: When a call and a return arrive together, the pop is applied first and the push second. On a nonempty stack the newest entry is replaced and `count_o` and `top_o` are unchanged. On an empty stack the pair acts as a plain push.
- R8: A load takes priority over a push or pop in the same cycle.
- R9: After reset, `count_o` and `top_o` are zero and `pred_valid_o` is low.
- R10: `top_o` wraps modulo DEPTH in both directions, on pushes and on pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empty the stack |
| call_i | input | 1 | Target predictor flags a call |
| call_next_pc_i | input | ADDR_W | Address of the instruction after the call |
| ret_i | input | 1 | Target predictor flags a return |
| load_i | input | 1 | Replace the whole stack from the image |
| load_image_i | input | DEPTH*ADDR_W | Image of all entries, entry i at bits i*ADDR_W |
| load_top_i | input | $clog2(DEPTH) | Pointer value to load |
| load_count_i | input | $clog2(DEPTH+1) | Occupancy value to load |
| pred_valid_o | output | 1 | Return prediction is valid |
| pred_target_o | output | ADDR_W | Predicted return target |
| top_o | output | $clog2(DEPTH) | Next write slot |
| count_o | output | $clog2(DEPTH+1) | Occupancy |

## Verification
A pointer that slips by one shows up at the very next return: the predicted target is an older or stale address, while the valid flag may still be correct. A wrong count shows up in two ways. It can produce a valid prediction after the last real entry has been popped, or it can withhold a prediction too early. Either is seen one return later than the faulty edge. Replacement of the oldest entry, and wrap after a load, only show up after a full ring of pops, so the stimulus drains the ring completely in both cases.

// File: rtl/rap_pkg.sv
package rap_pkg;
   typedef enum logic [2:0] {
      RAP_IDLE  = 3'd0,
      RAP_PUSH  = 3'd1,
      RAP_POP   = 3'd2,
      RAP_SWAP  = 3'd3,
      RAP_LOAD  = 3'd4,
      RAP_FLUSH = 3'd5
   } rap_op_e;
endpackage

// File: rtl/rap_ptr_ctl.sv
module rap_ptr_ctl
   import rap_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  rap_op_e       op_i,
   input  logic [PW-1:0] ld_top_i,
   input  logic [CW-1:0] ld_cnt_i,
   output logic [PW-1:0] top_o,
   output logic [CW-1:0] cnt_o,
   output logic          wr_en_o,
   output logic [PW-1:0] wr_idx_o,
   output logic [PW-1:0] rd_idx_o
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [PW-1:0] top_q, top_d, top_inc, top_dec, ld_top_fix;
   logic [CW-1:0] cnt_q, cnt_d;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign top_inc    = top_q + 1'b1;
         assign top_dec    = top_q - 1'b1;
         assign ld_top_fix = ld_top_i;
      end else begin : g_mod
         assign top_inc    = (top_q == LAST) ? '0 : top_q + 1'b1;
         assign top_dec    = (top_q == '0) ? LAST : top_q - 1'b1;
         assign ld_top_fix = (ld_top_i > LAST) ? LAST : ld_top_i;
      end
   endgenerate

   always_comb begin
      top_d    = top_q;
      cnt_d    = cnt_q;
      wr_en_o  = 1'b0;
      wr_idx_o = top_q;
      unique case (op_i)
         RAP_PUSH: begin
            wr_en_o = 1'b1;
            top_d   = top_inc;
            if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
         end
         RAP_POP: begin
            top_d = top_dec;
            cnt_d = cnt_q - 1'b1;
         end
         RAP_SWAP: begin
            wr_en_o  = 1'b1;
            wr_idx_o = top_dec;
         end
         RAP_LOAD: begin
            top_d = ld_top_fix;
            cnt_d = (ld_cnt_i > FULL) ? FULL : ld_cnt_i;
         end
         RAP_FLUSH: begin
            top_d = '0;
            cnt_d = '0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= '0;
         cnt_q <= '0;
      end else begin
         top_q <= top_d;
         cnt_q <= cnt_d;
      end
   end

   assign top_o    = top_q;
   assign cnt_o    = cnt_q;
   assign rd_idx_o = top_dec;

   // R3: occupancy never passes the depth
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
   // R3: a push on a full ring keeps it full
   a_r3_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == RAP_PUSH && cnt_q == FULL) |=> cnt_q == FULL);
   // R2: a push below full adds one entry
   a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == RAP_PUSH && cnt_q != FULL) |=> cnt_q == $past(cnt_q) + 1'b1);
   // R4: the decoder never hands an empty ring a pop
   a_r4_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == RAP_POP |-> cnt_q != '0);
   // R6: flush leaves the ring empty
   a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == RAP_FLUSH |=> (cnt_q == '0 && top_q == '0));
   // R10: the pointer always names a real slot
   a_r10_top_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      top_q <= LAST);
endmodule

// File: rtl/rap_entry_store.sv
module rap_entry_store #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 32,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_i,
   input  logic [DEPTH*ADDR_W-1:0] ld_image_i,
   input  logic                    wr_en_i,
   input  logic [PW-1:0]           wr_idx_i,
   input  logic [ADDR_W-1:0]       wr_data_i,
   input  logic [PW-1:0]           rd_idx_i,
   output logic [ADDR_W-1:0]       rd_data_o
);
   logic [ADDR_W-1:0] ent_w [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         logic [ADDR_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (ld_i)
               q <= ld_image_i[i*ADDR_W +: ADDR_W];
            else if (wr_en_i && wr_idx_i == PW'(i))
               q <= wr_data_i;
         end
         assign ent_w[i] = q;
      end
   endgenerate

   assign rd_data_o = ent_w[rd_idx_i];

   // R5: entry 0 holds the lowest slice of the image after a load
   a_r5_image_lands: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> ent_w[0] == $past(ld_image_i[ADDR_W-1:0]));
   // R2: a write reaches the slot it names
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !ld_i) |=> ent_w[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/ret_addr_predictor.sv
module ret_addr_predictor
   import rap_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 32,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush_i,
   input  logic                    call_i,
   input  logic [ADDR_W-1:0]       call_next_pc_i,
   input  logic                    ret_i,
   input  logic                    load_i,
   input  logic [DEPTH*ADDR_W-1:0] load_image_i,
   input  logic [PW-1:0]           load_top_i,
   input  logic [CW-1:0]           load_count_i,
   output logic                    pred_valid_o,
   output logic [ADDR_W-1:0]       pred_target_o,
   output logic [PW-1:0]           top_o,
   output logic [CW-1:0]           count_o
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ret_addr_predictor: DEPTH must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_width
         $error("ret_addr_predictor: ADDR_W must be positive");
      end
   endgenerate

   rap_op_e       op;
   logic          nonempty;
   logic          wr_en;
   logic [PW-1:0] wr_idx, rd_idx;

   assign nonempty = (count_o != '0);

   always_comb begin
      if (flush_i)                op = RAP_FLUSH;
      else if (load_i)            op = RAP_LOAD;
      else if (call_i && ret_i)   op = nonempty ? RAP_SWAP : RAP_PUSH;
      else if (call_i)            op = RAP_PUSH;
      else if (ret_i && nonempty) op = RAP_POP;
      else                        op = RAP_IDLE;
   end

   rap_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (op),
      .ld_top_i (load_top_i),
      .ld_cnt_i (load_count_i),
      .top_o    (top_o),
      .cnt_o    (count_o),
      .wr_en_o  (wr_en),
      .wr_idx_o (wr_idx),
      .rd_idx_o (rd_idx)
   );

   rap_entry_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_i       (load_i && !flush_i),
      .ld_image_i (load_image_i),
      .wr_en_i    (wr_en),
      .wr_idx_i   (wr_idx),
      .wr_data_i  (call_next_pc_i),
      .rd_idx_i   (rd_idx),
      .rd_data_o  (pred_target_o)
   );

   assign pred_valid_o = ret_i && nonempty;

   // R4: underflow leaves pointer and count alone
   a_r4_underflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i && !load_i && !flush_i && count_o == '0)
      |=> (count_o == '0 && $stable(top_o)));
   // R7: call plus return on a nonempty ring keeps the occupancy
   a_r7_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && ret_i && !load_i && !flush_i && count_o != '0)
      |=> ($stable(count_o) && $stable(top_o)));
   // R8: a load decides the pointer even with a push or pop pending
   a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !flush_i && (call_i || ret_i) && ((DEPTH & (DEPTH - 1)) == 0))
      |=> top_o == $past(load_top_i));
   // R1: a pop lowers the count by one
   a_r1_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_valid_o && !call_i && !load_i && !flush_i)
      |=> count_o == $past(count_o) - 1'b1);
endmodule

// File: tb/ret_addr_predictor_tb.sv
module ret_addr_predictor_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 4;
   localparam int ADDR_W = 16;
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int NVEC = 16;

   // fields: call, ret, addr[16], exp valid, exp target[16], exp count[3], exp top[2]
   localparam logic [39:0] TBL [NVEC] = '{
      {1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd0, 2'd0},  // R4 underflow
      {1'b1, 1'b0, 16'h1004, 1'b0, 16'h0000, 3'd1, 2'd1},  // R2
      {1'b1, 1'b0, 16'h2008, 1'b0, 16'h0000, 3'd2, 2'd2},  // R2
      {1'b0, 1'b1, 16'h0000, 1'b1, 16'h2008, 3'd1, 2'd1},  // R1
      {1'b1, 1'b1, 16'h3000, 1'b1, 16'h1004, 3'd1, 2'd1},  // R7 swap
      {1'b0, 1'b1, 16'h0000, 1'b1, 16'h3000, 3'd0, 2'd0},  // R7 new top
      {1'b1, 1'b1, 16'h4000, 1'b0, 16'h0000, 3'd1, 2'd1},  // R7 empty pair
      {1'b1, 1'b0, 16'h5000, 1'b0, 16'h0000, 3'd2, 2'd2},
      {1'b1, 1'b0, 16'h6000, 1'b0, 16'h0000, 3'd3, 2'd3},
      {1'b1, 1'b0, 16'h7000, 1'b0, 16'h0000, 3'd4, 2'd0},  // R10 wrap
      {1'b1, 1'b0, 16'h8000, 1'b0, 16'h0000, 3'd4, 2'd1},  // R3 overwrite
      {1'b0, 1'b1, 16'h0000, 1'b1, 16'h8000, 3'd3, 2'd0},  // R3
      {1'b0, 1'b1, 16'h0000, 1'b1, 16'h7000, 3'd2, 2'd3},  // R10 back
      {1'b0, 1'b1, 16'h0000, 1'b1, 16'h6000, 3'd1, 2'd2},
      {1'b0, 1'b1, 16'h0000, 1'b1, 16'h5000, 3'd0, 2'd1},  // R3 oldest gone
      {1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd0, 2'd1}   // R4
   };

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    flush_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, load_i = 1'b0;
   logic [ADDR_W-1:0]       call_next_pc_i = '0;
   logic [DEPTH*ADDR_W-1:0] load_image_i = '0;
   logic [PW-1:0]           load_top_i = '0;
   logic [CW-1:0]           load_count_i = '0;
   logic                    pred_valid_o;
   logic [ADDR_W-1:0]       pred_target_o;
   logic [PW-1:0]           top_o;
   logic [CW-1:0]           count_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ret_addr_predictor #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .call_i(call_i),
      .call_next_pc_i(call_next_pc_i), .ret_i(ret_i), .load_i(load_i),
      .load_image_i(load_image_i), .load_top_i(load_top_i),
      .load_count_i(load_count_i), .pred_valid_o(pred_valid_o),
      .pred_target_o(pred_target_o), .top_o(top_o), .count_o(count_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      flush_i = 1'b0; call_i = 1'b0; ret_i = 1'b0; load_i = 1'b0;
   endtask

   // one return: check prediction before the edge, state after it
   task automatic pop_check(input string req, input logic ev, input logic [15:0] et,
                            input logic [2:0] ec, input logic [1:0] etop);
      @(negedge clk);
      idle_inputs();
      ret_i = 1'b1;
      #1;
      chk({req, " valid"}, 32'(pred_valid_o), 32'(ev));
      if (ev) chk({req, " target"}, 32'(pred_target_o), 32'(et));
      @(posedge clk); #1;
      chk({req, " count"}, 32'(count_o), 32'(ec));
      chk({req, " top"}, 32'(top_o), 32'(etop));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R9 reset state
      ret_i = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk("R9 count", 32'(count_o), 0);
      chk("R9 top", 32'(top_o), 0);
      chk("R9 valid", 32'(pred_valid_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      ret_i = 1'b0;

      for (int k = 0; k < NVEC; k++) begin
         @(negedge clk);
         idle_inputs();
         call_i = TBL[k][39];
         ret_i = TBL[k][38];
         call_next_pc_i = TBL[k][37:22];
         #1;
         chk($sformatf("vec%0d R1/R4 valid", k), 32'(pred_valid_o), 32'(TBL[k][21]));
         if (TBL[k][21])
            chk($sformatf("vec%0d R1 target", k), 32'(pred_target_o), 32'(TBL[k][20:5]));
         @(posedge clk); #1;
         chk($sformatf("vec%0d R2/R3 count", k), 32'(count_o), 32'(TBL[k][4:2]));
         chk($sformatf("vec%0d R10 top", k), 32'(top_o), 32'(TBL[k][1:0]));
      end

      // R5 and R8: load with a call pending; the call is ignored
      @(negedge clk);
      idle_inputs();
      load_i = 1'b1;
      call_i = 1'b1;
      call_next_pc_i = 16'hDEAD;
      load_image_i = {16'hA003, 16'hA002, 16'hA001, 16'hA000};
      load_top_i = 2'd2;
      load_count_i = 3'd3;
      @(posedge clk); #1;
      chk("R8 count", 32'(count_o), 3);
      chk("R8 top", 32'(top_o), 2);
      pop_check("R5 entry1", 1'b1, 16'hA001, 3'd2, 2'd1);
      pop_check("R5 entry0", 1'b1, 16'hA000, 3'd1, 2'd0);
      pop_check("R10 wrap entry3", 1'b1, 16'hA003, 3'd0, 2'd3);
      pop_check("R4 after drain", 1'b0, 16'h0000, 3'd0, 2'd3);

      // R5 count clamp
      @(negedge clk);
      idle_inputs();
      load_i = 1'b1;
      load_top_i = 2'd0;
      load_count_i = 3'd7;
      @(posedge clk); #1;
      chk("R5 clamp", 32'(count_o), DEPTH);

      // R6 flush beats a load
      @(negedge clk);
      idle_inputs();
      flush_i = 1'b1;
      load_i = 1'b1;
      load_top_i = 2'd3;
      load_count_i = 3'd2;
      @(posedge clk); #1;
      chk("R6 count", 32'(count_o), 0);
      chk("R6 top", 32'(top_o), 0);
      pop_check("R6 no pred", 1'b0, 16'h0000, 3'd0, 2'd0);

      @(negedge clk);
      idle_inputs();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule